// File: doc/BRIEF.md
# RAM-Disk Sector Store Controller

This block turns a multiplexed-address DRAM into a small disk that a host CPU reaches through a handful of I/O ports. The host picks a sector by writing its number in two byte-wide halves. It then streams the whole 512-byte sector through one data port, one byte per strobe. Each data-port access runs one full DRAM cycle: the row is the sector number and the column is the byte offset. The store holds at least 400 sectors, which is one single-sided 40-track image of 10 sectors per track.

Writes are guarded. The host must first write the unlock port, then the low half of the sector number, then the high half. Only then do data-port writes reach memory. Anything out of that order leaves the store protected.

When the host is not moving a byte, an interval timer requests RAS-only refresh cycles. These walk through all 512 rows in turn. A refresh that falls due during a host byte waits until that byte has finished.

Top module: `ramdisk_ctrl`

## Requirements
- R1: After reset, RAS, CAS and WE are high, busy is low and the read-data register is 0x00.
- R2: Port codes are 0 data, 1 sector low byte, 2 sector high byte, 3 unlock and 4 status. A status read returns bit 0 = sector out of range and bit 1 = writes armed, with the other bits zero. A read of any port other than data or status returns 0x00.
- R3: The write sequence arms the store: a write to unlock, then sector low, then sector high. After it, data-port writes store bytes at the selected sector and offset.
- R4: A data-port write made while writes are not armed leaves memory unchanged.
- R5: The arm is dropped by any data-port read, and by a sector-byte write that does not follow its step in the sequence (sector low needs unlock just before it, sector high needs sector low just before it).
- R6: A write to either sector byte resets the byte offset to 0. Every data-port access outside the error state advances the offset by 1, including rejected writes. After offset 511 the offset wraps to 0 and the arm drops.
- R7: A data-port read needs no unlock. It returns the byte at the current sector and offset once busy falls.
- R8: A sector number of 400 or more sets status bit 0. While that bit is set, data-port accesses start no DRAM cycle and leave the offset unchanged, and a data read returns 0xFF.
- R9: A data access drives the low 9 bits of the sector number as the row while RAS falls. It then drives the offset as the column with CAS, with WE low only for a write. Busy is high for exactly 3 cycles.
- R10: Every REF_INTERVAL cycles a refresh is requested. It runs as a RAS-only cycle (CAS stays high), and successive refreshes use rows that step by 1 modulo 512.
- R11: A refresh never starts inside a host DRAM access. Each RAS window holds either no CAS (refresh) or exactly one CAS (host byte).
- R12: Sector 399 is in range and all 512 of its bytes can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | One-cycle I/O write strobe, taken only while busy is low |
| io_rd_i | input | 1 | One-cycle I/O read strobe, taken only while busy is low |
| io_port_i | input | 3 | Port code |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data register |
| io_busy_o | output | 1 | DRAM cycle (host or refresh) in progress |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_addr_o | output | 9 | Multiplexed row/column address |
| dram_dq_o | output | 8 | Data to DRAM |
| dram_dq_i | input | 8 | Data from DRAM |

## Verification
The assertions check these rules on every cycle:
- CAS falls only after RAS has already been low for a cycle, and WE is never low without CAS.
- A refresh never follows a host row or column phase directly.
- The refresh row only ever steps by one.
- The offset only steps by one or returns to zero.
- A data read always drops the arm, and an out-of-range sector freezes the offset.

Only the bench scenarios can show the following:
- Bytes really land at sector times 512 plus offset.
- Unarmed and out-of-order writes leave memory untouched.
- Rejected writes still advance the offset.
- The wrap after 512 bytes both disarms and returns to offset 0.
- The refresh walk covers the full 512-row cycle.

// File: rtl/ramdisk_pkg.sv
package ramdisk_pkg;
  localparam logic [2:0] PORT_DATA   = 3'd0;
  localparam logic [2:0] PORT_SEC_LO = 3'd1;
  localparam logic [2:0] PORT_SEC_HI = 3'd2;
  localparam logic [2:0] PORT_UNLOCK = 3'd3;
  localparam logic [2:0] PORT_STATUS = 3'd4;

  typedef enum logic [1:0] {SEQ_LOCKED, SEQ_UNLK, SEQ_LO, SEQ_ARMED} wr_seq_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_PRE, ST_REF, ST_RPRE
  } dram_st_e;
endpackage

// File: rtl/ramdisk_host_regs.sv
module ramdisk_host_regs import ramdisk_pkg::*; #(
  parameter int SECTOR_BYTES = 512,
  parameter int NUM_SECTORS  = 400,
  parameter int ROW_W        = 9,
  localparam int OFF_W       = $clog2(SECTOR_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [2:0]       port_i,
  input  logic [7:0]       wdata_i,
  output logic             data_adv_o,
  output logic             dram_go_o,
  output logic             dram_we_o,
  output logic [ROW_W-1:0] row_o,
  output logic [OFF_W-1:0] col_o,
  output logic             err_o,
  output logic             armed_o
);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(SECTOR_BYTES - 1);

  logic [7:0]       sec_lo_q, sec_hi_q;
  logic [15:0]      sector;
  logic [OFF_W-1:0] off_q;
  wr_seq_e          seq_q;
  logic             wr_ok, rd_ok, data_wr, data_rd, wrap;

  assign sector  = {sec_hi_q, sec_lo_q};
  assign err_o   = int'(sector) >= NUM_SECTORS;
  assign armed_o = (seq_q == SEQ_ARMED);
  assign row_o   = sector[ROW_W-1:0];
  assign col_o   = off_q;

  assign wr_ok      = idle_i & wr_i;
  assign rd_ok      = idle_i & rd_i;
  assign data_wr    = wr_ok && port_i == PORT_DATA && !err_o;
  assign data_rd    = rd_ok && port_i == PORT_DATA && !err_o;
  assign data_adv_o = data_wr | data_rd;
  // rejected writes advance the offset but skip the DRAM cycle
  assign dram_go_o  = data_rd | (data_wr & armed_o);
  assign dram_we_o  = data_wr;
  assign wrap       = data_adv_o && off_q == OFF_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_lo_q <= '0;
      sec_hi_q <= '0;
    end else if (wr_ok && port_i == PORT_SEC_LO) begin
      sec_lo_q <= wdata_i;
    end else if (wr_ok && port_i == PORT_SEC_HI) begin
      sec_hi_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
    end else if (wr_ok && (port_i == PORT_SEC_LO || port_i == PORT_SEC_HI)) begin
      off_q <= '0;
    end else if (data_adv_o) begin
      off_q <= wrap ? '0 : off_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= SEQ_LOCKED;
    end else if (wr_ok) begin
      case (port_i)
        PORT_UNLOCK: seq_q <= SEQ_UNLK;
        PORT_SEC_LO: seq_q <= (seq_q == SEQ_UNLK) ? SEQ_LO : SEQ_LOCKED;
        PORT_SEC_HI: seq_q <= (seq_q == SEQ_LO) ? SEQ_ARMED : SEQ_LOCKED;
        PORT_DATA:   if (wrap) seq_q <= SEQ_LOCKED;
        default:     ;
      endcase
    end else if (rd_ok && port_i == PORT_DATA) begin
      seq_q <= SEQ_LOCKED;
    end
  end

  a_r6_offset_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_q != $past(off_q)) |-> (off_q == '0 || off_q == $past(off_q) + 1'b1))
    else $error("offset jumped");

  a_r8_err_freezes_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && idle_i && (rd_i || wr_i) && port_i == PORT_DATA) |=> $stable(off_q))
    else $error("offset moved in error state");

  a_r5_read_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && port_i == PORT_DATA) |=> !armed_o)
    else $error("data read left writes armed");
endmodule

// File: rtl/ramdisk_refresh.sv
module ramdisk_refresh #(
  parameter int ROW_W        = 9,
  parameter int REF_INTERVAL = 64,
  localparam int TMR_W       = $clog2(REF_INTERVAL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             host_req_i,
  output logic             ref_go_o,
  output logic [ROW_W-1:0] ref_row_o
);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REF_INTERVAL - 1);

  logic [TMR_W-1:0] tmr_q;
  logic             pend_q, expire;
  logic [ROW_W-1:0] row_q;

  assign expire    = (tmr_q == TMR_LAST);
  // host strobes win; refresh waits for a quiet idle cycle
  assign ref_go_o  = pend_q & idle_i & ~host_req_i;
  assign ref_row_o = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      tmr_q  <= expire ? '0 : tmr_q + 1'b1;
      pend_q <= (pend_q & ~ref_go_o) | expire;
      if (ref_go_o) row_q <= row_q + 1'b1;
    end
  end

  a_r10_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_q != $past(row_q)) |-> (row_q == $past(row_q) + 1'b1))
    else $error("refresh row skipped");
endmodule

// File: rtl/ramdisk_dram_seq.sv
module ramdisk_dram_seq import ramdisk_pkg::*; #(
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [7:0]        wdata_i,
  input  logic              ref_go_i,
  input  logic [ROW_W-1:0]  ref_row_i,
  output logic              idle_o,
  output logic              cap_o,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        dq_o
);
  dram_st_e         st_q, st_d;
  logic [ROW_W-1:0] row_l;
  logic [COL_W-1:0] col_l;
  logic [7:0]       wd_l;
  logic             we_l;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (go_i) st_d = ST_ROW;
               else if (ref_go_i) st_d = ST_REF;
      ST_ROW:  st_d = ST_COL;
      ST_COL:  st_d = ST_PRE;
      ST_PRE:  st_d = ST_IDLE;
      ST_REF:  st_d = ST_RPRE;
      ST_RPRE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      row_l <= '0;
      col_l <= '0;
      wd_l  <= '0;
      we_l  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && go_i) begin
        row_l <= row_i;
        col_l <= col_i;
        wd_l  <= wdata_i;
        we_l  <= we_i;
      end else if (st_q == ST_IDLE && ref_go_i) begin
        row_l <= ref_row_i;
        we_l  <= 1'b0;
      end
    end
  end

  assign idle_o = (st_q == ST_IDLE);
  assign cap_o  = (st_q == ST_COL) && !we_l;
  assign ras_no = !(st_q == ST_ROW || st_q == ST_COL || st_q == ST_REF);
  assign cas_no = !(st_q == ST_COL);
  assign we_no  = !(st_q == ST_COL && we_l);
  assign addr_o = (st_q == ST_COL) ? ADDR_W'(col_l) : ADDR_W'(row_l);
  assign dq_o   = wd_l;

  a_r9_ras_before_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> (!ras_no && $past(!ras_no)))
    else $error("CAS fell without RAS held");

  a_r9_we_with_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !cas_no)
    else $error("WE low without CAS");

  a_r11_no_ref_in_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ROW || st_q == ST_COL) |=> (st_q != ST_REF))
    else $error("refresh broke into host access");
endmodule

// File: rtl/ramdisk_ctrl.sv
module ramdisk_ctrl import ramdisk_pkg::*; #(
  parameter int SECTOR_BYTES = 512,
  parameter int NUM_SECTORS  = 400,
  parameter int ROW_W        = 9,
  parameter int REF_INTERVAL = 64,
  localparam int COL_W       = $clog2(SECTOR_BYTES),
  localparam int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [2:0]        io_port_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              io_busy_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_we_no,
  output logic [ADDR_W-1:0] dram_addr_o,
  output logic [7:0]        dram_dq_o,
  input  logic [7:0]        dram_dq_i
);
  logic             idle, data_adv, go, we, err, armed, ref_go, cap;
  logic [ROW_W-1:0] row, ref_row;
  logic [COL_W-1:0] col;
  logic [7:0]       rdata_q;
  logic             rd_ok;

  ramdisk_host_regs #(
    .SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS), .ROW_W(ROW_W)
  ) u_regs (
    .clk_i, .rst_ni, .idle_i(idle), .wr_i(io_wr_i), .rd_i(io_rd_i),
    .port_i(io_port_i), .wdata_i(io_wdata_i), .data_adv_o(data_adv),
    .dram_go_o(go), .dram_we_o(we), .row_o(row), .col_o(col),
    .err_o(err), .armed_o(armed)
  );

  ramdisk_refresh #(.ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i, .rst_ni, .idle_i(idle), .host_req_i(io_wr_i | io_rd_i),
    .ref_go_o(ref_go), .ref_row_o(ref_row)
  );

  ramdisk_dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk_i, .rst_ni, .go_i(go), .we_i(we), .row_i(row), .col_i(col),
    .wdata_i(io_wdata_i), .ref_go_i(ref_go), .ref_row_i(ref_row),
    .idle_o(idle), .cap_o(cap), .ras_no(dram_ras_no), .cas_no(dram_cas_no),
    .we_no(dram_we_no), .addr_o(dram_addr_o), .dq_o(dram_dq_o)
  );

  assign rd_ok = idle & io_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= 8'h00;
    end else if (rd_ok && io_port_i == PORT_STATUS) begin
      rdata_q <= {6'b0, armed, err};
    end else if (rd_ok && io_port_i == PORT_DATA) begin
      if (err) rdata_q <= 8'hFF;
    end else if (rd_ok) begin
      rdata_q <= 8'h00;
    end else if (cap) begin
      rdata_q <= dram_dq_i;
    end
  end

  assign io_rdata_o = rdata_q;
  assign io_busy_o  = ~idle;

  a_r8_no_cycle_in_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && err && (io_rd_i || io_wr_i) && io_port_i == PORT_DATA) |=> idle)
    else $error("DRAM cycle started in error state");

  a_r6_advance_only_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_adv |-> (io_port_i == PORT_DATA && !err))
    else $error("offset advance without data access");
endmodule

// File: tb/ramdisk_ctrl_tb.sv
module ramdisk_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [2:0] io_port = 3'd0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       busy, ras_n, cas_n, we_n;
  logic [8:0] addr;
  logic [7:0] dq_o;
  logic [7:0] dq_i = 8'h00;

  int checks = 0, errors = 0;
  logic [7:0] dmem [int];
  logic [7:0] exp_mem [int];
  logic [8:0] row_lat = '0, last_ref_row = '0;
  logic       prev_ras = 1'b1, prev_cas = 1'b1, have_ref = 1'b0;
  int         win_cas = 0, cas_total = 0, ref_events = 0, ref_step_err = 0, bad_win = 0;

  always #2 clk = ~clk;

  ramdisk_ctrl u_dut (
    .clk_i(clk), .rst_ni, .io_wr_i(io_wr), .io_rd_i(io_rd), .io_port_i(io_port),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .io_busy_o(busy),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
    .dram_addr_o(addr), .dram_dq_o(dq_o), .dram_dq_i(dq_i)
  );

  // behavioural DRAM plus window monitor
  always @(posedge clk) begin
    if (!ras_n && prev_ras) begin row_lat = addr; win_cas = 0; end
    if (!cas_n && prev_cas) begin cas_total++; win_cas++; end
    if (!cas_n && !we_n) dmem[int'({row_lat, addr})] = dq_o;
    if (ras_n && !prev_ras) begin
      if (win_cas == 0) begin
        if (have_ref && row_lat != last_ref_row + 9'd1) ref_step_err++;
        last_ref_row = row_lat; have_ref = 1'b1; ref_events++;
      end else if (win_cas != 1) bad_win++;
    end
    prev_ras = ras_n;
    prev_cas = cas_n;
  end

  always @(negedge clk)
    if (!ras_n && !cas_n)
      dq_i <= dmem.exists(int'({row_lat, addr})) ? dmem[int'({row_lat, addr})] : 8'h00;

  function automatic int lin(input int sec, input int off);
    return sec * 512 + off;
  endfunction

  function automatic logic [7:0] exp_at(input int a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic io_wr_t(input logic [2:0] p, input logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    io_wr = 1'b1; io_port = p; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic io_rd_t(input logic [2:0] p, output logic [7:0] d, output int bcyc);
    @(negedge clk);
    while (busy) @(negedge clk);
    io_rd = 1'b1; io_port = p;
    @(negedge clk);
    io_rd = 1'b0;
    bcyc = 0;
    while (busy) begin bcyc++; @(negedge clk); end
    d = io_rdata;
  endtask

  task automatic rd_status(output logic [7:0] s);
    int n;
    io_rd_t(3'd4, s, n);
  endtask

  task automatic select(input int sec, input bit arm);
    if (arm) io_wr_t(3'd3, 8'h00);
    io_wr_t(3'd1, sec[7:0]);
    io_wr_t(3'd2, sec[15:8]);
  endtask

  task automatic fill_sector(input int sec, input bit rnd);
    logic [7:0] v;
    select(sec, 1'b1);
    for (int i = 0; i < 512; i++) begin
      v = rnd ? 8'($urandom) : 8'(i * 7 + 3);
      io_wr_t(3'd0, v);
      exp_mem[lin(sec, i)] = v;
    end
  endtask

  task automatic verify_sector(input int sec, input string req);
    logic [7:0] d;
    int n, bad;
    bad = 0;
    select(sec, 1'b0);
    for (int i = 0; i < 512; i++) begin
      io_rd_t(3'd0, d, n);
      if (d != exp_at(lin(sec, i))) begin
        if (bad == 0) check(1'b0, req, d, exp_at(lin(sec, i)));
        bad++;
      end
    end
    if (bad == 0) check(1'b1, req, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, s;
    int n, cas0, ref0, sec;
    int secs [3];
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ras_n && cas_n && we_n, "R1 strobes idle", {ras_n, cas_n, we_n}, 3'b111);
    check(!busy, "R1 busy low", busy, 0);
    check(io_rdata == 8'h00, "R1 rdata", io_rdata, 0);
    // R2 port map
    rd_status(s);
    check(s == 8'h00, "R2 status after reset", s, 0);
    io_rd_t(3'd5, d, n);
    check(d == 8'h00, "R2 unused port reads zero", d, 0);
    io_rd_t(3'd3, d, n);
    check(d == 8'h00, "R2 unlock port reads zero", d, 0);

    // R3 armed write of sector 5
    select(5, 1'b1);
    rd_status(s);
    check(s == 8'h02, "R3 armed status", s, 2);
    ref0 = ref_events;
    fill_sector(5, 1'b0);
    check(ref_events > ref0, "R11 refresh between host bytes", ref_events - ref0, 1);
    check(bad_win == 0, "R11 RAS windows clean", bad_win, 0);
    rd_status(s);
    check(s == 8'h00, "R6 wrap disarms", s, 0);
    // R9 mapping: row = sector, column = offset
    check(dmem.exists(lin(5, 0)) && dmem[lin(5, 0)] == exp_at(lin(5, 0)),
          "R9 byte 0 at row 5 col 0", dmem.exists(lin(5, 0)) ? dmem[lin(5, 0)] : -1, exp_at(lin(5, 0)));
    check(dmem.exists(lin(5, 511)) && dmem[lin(5, 511)] == exp_at(lin(5, 511)),
          "R9 byte 511 at row 5 col 511", dmem.exists(lin(5, 511)) ? dmem[lin(5, 511)] : -1, exp_at(lin(5, 511)));
    // R4 write after wrap is rejected
    io_wr_t(3'd0, 8'hAA);
    select(5, 1'b0);
    io_rd_t(3'd0, d, n);
    check(d == exp_at(lin(5, 0)), "R4 post-wrap write ignored", d, exp_at(lin(5, 0)));
    check(n == 3, "R9 busy 3 cycles on read", n, 3);
    // R7 read back remaining bytes, no unlock
    verify_sector(5, "R7 sector 5 readback");

    // R6 rejected writes still advance offset; R4 memory untouched
    select(5, 1'b0);
    for (int i = 0; i < 10; i++) io_wr_t(3'd0, 8'h55);
    io_rd_t(3'd0, d, n);
    check(d == exp_at(lin(5, 10)), "R6 offset advanced by rejected writes", d, exp_at(lin(5, 10)));
    select(5, 1'b0);
    io_rd_t(3'd0, d, n);
    check(d == exp_at(lin(5, 0)), "R4 unarmed write left byte 0", d, exp_at(lin(5, 0)));

    // R5 sequence order
    io_wr_t(3'd3, 8'h00); io_wr_t(3'd2, 8'h00); io_wr_t(3'd1, 8'h05);
    rd_status(s);
    check(s == 8'h00, "R5 hi before lo stays locked", s, 0);
    io_wr_t(3'd3, 8'h00); io_wr_t(3'd1, 8'h05); io_wr_t(3'd1, 8'h05); io_wr_t(3'd2, 8'h00);
    rd_status(s);
    check(s == 8'h00, "R5 repeated lo stays locked", s, 0);
    select(5, 1'b1);
    io_rd_t(3'd0, d, n);
    rd_status(s);
    check(s == 8'h00, "R5 data read disarms", s, 0);
    io_wr_t(3'd0, 8'h77);
    select(5, 1'b0);
    io_rd_t(3'd0, d, n);
    io_rd_t(3'd0, d, n);
    check(d == exp_at(lin(5, 1)), "R5 write after read-disarm ignored", d, exp_at(lin(5, 1)));

    // R8 out-of-range sector
    select(400, 1'b1);
    rd_status(s);
    check(s == 8'h03, "R8 error bit at 400", s, 3);
    cas0 = cas_total;
    io_rd_t(3'd0, d, n);
    check(d == 8'hFF, "R8 read in error returns FF", d, 8'hFF);
    io_wr_t(3'd0, 8'h12);
    check(cas_total == cas0, "R8 no DRAM cycle in error", cas_total - cas0, 0);
    select(16'hFFFF, 1'b0);
    rd_status(s);
    check(s == 8'h01, "R8 error bit at 65535", s, 1);

    // R12 last sector
    select(399, 1'b0);
    rd_status(s);
    check(s == 8'h00, "R12 sector 399 in range", s, 0);
    fill_sector(399, 1'b1);
    check(dmem.exists(lin(399, 511)) && dmem[lin(399, 511)] == exp_at(lin(399, 511)),
          "R12 top byte stored", dmem.exists(lin(399, 511)) ? dmem[lin(399, 511)] : -1, exp_at(lin(399, 511)));
    verify_sector(399, "R12 sector 399 readback");

    // R3/R7 random sectors
    for (int k = 0; k < 3; k++) begin
      sec = $urandom_range(0, 398);
      if (sec == 5) sec = 6;
      secs[k] = sec;
      fill_sector(sec, 1'b1);
    end
    for (int k = 0; k < 3; k++) verify_sector(secs[k], "R3 random sector readback");
    check(bad_win == 0, "R11 windows after traffic", bad_win, 0);

    // R10 idle refresh walk covering a row wrap
    ref0 = ref_events;
    repeat (34000) @(negedge clk);
    check(ref_events - ref0 >= 520, "R10 refresh count", ref_events - ref0, 520);
    check(ref_step_err == 0, "R10 row step", ref_step_err, 0);
    check(bad_win == 0, "R10 RAS-only refresh", bad_win, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule